// File: doc/BRIEF.md
# Half-Word Bus Width Adapter

This block sits at the edge of a queue and lets the producer side and the consumer side each run either a full-width bus (two halves of `HALF_W` bits, 18 bits by default) or a half-width bus (9 bits by default). Each side's width and the order of the two halves inside a full word are captured while the synchronous reset is held and stay in force until the next reset.

When the widths differ, two consecutive narrow input transfers are joined into one wide output word, or one wide input word is split into two consecutive narrow output transfers. When the widths match, a word passes through a single register stage. Both sides use a valid/ready handshake. A word that is only half built when reset arrives is dropped. A partial word is never shown as valid.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst_n` is low, `cfg_in_narrow` and `cfg_out_narrow` are captured on each clock edge. Low selects a full-width (2*HALF_W) port and high selects a half-width (HALF_W) port. For every input transfer pattern, the number of output transfers matches the captured widths: two narrow inputs give one wide output, one wide input gives two narrow outputs, and with equal widths there is one output per input.
- R2: While `rst_n` is low, `cfg_little` is captured. Low selects big-endian half order and high selects little-endian half order.
- R3: After `rst_n` goes high, changes on the three configuration inputs have no effect until the next reset.
- R4: Big-endian, narrow in, wide out: the first narrow word lands in the upper half (bits 17:9) and the second lands in the lower half (bits 8:0).
- R5: Little-endian, narrow in, wide out: the first narrow word lands in the lower half and the second lands in the upper half.
- R6: Big-endian, wide in, narrow out: the upper half is presented first and the lower half second.
- R7: Little-endian, wide in, narrow out: the lower half is presented first and the upper half second.
- R8: With equal widths, data passes unchanged through one register stage. A word accepted at a clock edge is presented valid right after that same edge.
- R9: On a narrow input port the upper input bits are ignored. On a narrow output port the upper output bits are driven zero.
- R10: While `rst_n` is low, `in_ready` and `out_valid` are low. One clock edge of reset clears `out_valid`. A half-assembled word is discarded by reset and never appears at the output.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. When all internal storage is full, `in_ready` is low, so no data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is captured while low |
| cfg_in_narrow | input | 1 | Input width select: 0 = full width, 1 = half width |
| cfg_out_narrow | input | 1 | Output width select: 0 = full width, 1 = half width |
| cfg_little | input | 1 | Half order: 0 = big-endian, 1 = little-endian |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Adapter can take an input word |
| in_data | input | 2*HALF_W | Input word; only the low HALF_W bits are used on a narrow port |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 2*HALF_W | Output word; upper HALF_W bits are zero on a narrow port |

## Verification
The last transfer that completes an output (the only input in pass-through and split modes, the second half in join mode) makes `out_valid` rise right after the clock edge that accepts it. In split mode the second half follows on the edge that pops the first half. `in_ready` is combinational from `out_ready` and from internal state. For that reason the bench drives inputs on the falling edge and reads `in_ready`, `out_valid` and `out_data` one time step later. A transfer counts as taken exactly when both sides of a handshake are high at that read, so every recorded word matches what the next rising edge does. The latency case checks that `out_valid` is still low before the accepting edge and high after it. The stall case holds `out_ready` low over several edges and checks that the output stays put.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

   typedef enum logic [1:0] {
      BWA_PASS_WIDE   = 2'd0,
      BWA_PASS_NARROW = 2'd1,
      BWA_JOIN        = 2'd2,
      BWA_SPLIT       = 2'd3
   } bwa_mode_e;

   function automatic bwa_mode_e bwa_mode_of(input logic in_narrow, input logic out_narrow);
      bwa_mode_e m;
      case ({in_narrow, out_narrow})
         2'b00:   m = BWA_PASS_WIDE;
         2'b11:   m = BWA_PASS_NARROW;
         2'b10:   m = BWA_JOIN;
         default: m = BWA_SPLIT;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
   import bwa_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_in_narrow,
   input  logic      cfg_out_narrow,
   input  logic      cfg_little,
   output bwa_mode_e mode,
   output logic      little
);

   bwa_mode_e mode_q;
   logic      little_q;

   // Capture only while reset is held; hold afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= bwa_mode_of(cfg_in_narrow, cfg_out_narrow);
         little_q <= cfg_little;
      end
   end

   assign mode   = mode_q;
   assign little = little_q;

endmodule

// File: rtl/bwa_pass.sv
module bwa_pass #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_word,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_word
);

   logic         v_q;
   logic [W-1:0] d_q;
   logic         acc;

   assign in_ready = !v_q || out_ready;
   assign acc      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         d_q <= '0;
      end else if (acc) begin
         v_q <= 1'b1;
         d_q <= in_word;
      end else if (out_ready) begin
         v_q <= 1'b0;
      end
   end

   assign out_valid = v_q;
   assign out_word  = d_q;

endmodule

// File: rtl/bwa_join.sv
module bwa_join #(
   parameter int HALF_W = 9,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              little,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [HALF_W-1:0] in_half,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [FULL_W-1:0] out_word
);

   logic              hold_v, word_v;
   logic [HALF_W-1:0] hold_q;
   logic [FULL_W-1:0] word_q;
   logic              acc;

   // A first half always fits once the holding slot is free;
   // a second half needs the word slot free or draining.
   assign in_ready = !hold_v || !word_v || out_ready;
   assign acc      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         word_v <= 1'b0;
         hold_q <= '0;
         word_q <= '0;
      end else begin
         if (acc && !hold_v) begin
            hold_q <= in_half;
            hold_v <= 1'b1;
         end
         if (acc && hold_v) begin
            word_q <= little ? {in_half, hold_q} : {hold_q, in_half};
            word_v <= 1'b1;
            hold_v <= 1'b0;
         end else if (word_v && out_ready) begin
            word_v <= 1'b0;
         end
      end
   end

   assign out_valid = word_v;
   assign out_word  = word_q;

endmodule

// File: rtl/bwa_split.sv
module bwa_split #(
   parameter int HALF_W = 9,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              little,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FULL_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [HALF_W-1:0] out_half
);

   logic              buf_v, second;
   logic [FULL_W-1:0] buf_q;
   logic [HALF_W-1:0] hi_h, lo_h, first_h, last_h;
   logic              pop, done;

   assign hi_h    = buf_q[FULL_W-1:HALF_W];
   assign lo_h    = buf_q[HALF_W-1:0];
   assign first_h = little ? lo_h : hi_h;
   assign last_h  = little ? hi_h : lo_h;

   assign pop      = buf_v && out_ready;
   assign done     = pop && second;
   assign in_ready = !buf_v || done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_v  <= 1'b0;
         second <= 1'b0;
         buf_q  <= '0;
      end else if (in_valid && in_ready) begin
         buf_q  <= in_word;
         buf_v  <= 1'b1;
         second <= 1'b0;
      end else if (done) begin
         buf_v  <= 1'b0;
         second <= 1'b0;
      end else if (pop) begin
         second <= 1'b1;
      end
   end

   assign out_valid = buf_v;
   assign out_half  = second ? last_h : first_h;

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
   import bwa_pkg::*;
#(
   parameter int HALF_W = 9,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_in_narrow,
   input  logic              cfg_out_narrow,
   input  logic              cfg_little,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FULL_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [FULL_W-1:0] out_data
);

   generate
      if (HALF_W < 1) begin : g_bad_width
         $error("bus_width_adapter: HALF_W must be at least 1");
      end
   endgenerate

   bwa_mode_e mode;
   logic      little;

   bwa_cfg_latch u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_in_narrow  (cfg_in_narrow),
      .cfg_out_narrow (cfg_out_narrow),
      .cfg_little     (cfg_little),
      .mode           (mode),
      .little         (little)
   );

   logic              narrow_in;
   logic [FULL_W-1:0] din_m;

   assign narrow_in = (mode == BWA_PASS_NARROW) || (mode == BWA_JOIN);
   assign din_m     = narrow_in ? {{HALF_W{1'b0}}, in_data[HALF_W-1:0]} : in_data;

   logic              pw_rdy, pn_rdy, jn_rdy, sp_rdy;
   logic              pw_ov,  pn_ov,  jn_ov,  sp_ov;
   logic [FULL_W-1:0] pw_d,   pn_d,   jn_d;
   logic [HALF_W-1:0] sp_d;

   bwa_pass #(.W(FULL_W)) u_pass_wide (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid && (mode == BWA_PASS_WIDE)),
      .in_ready  (pw_rdy),
      .in_word   (din_m),
      .out_valid (pw_ov),
      .out_ready (out_ready),
      .out_word  (pw_d)
   );

   bwa_pass #(.W(FULL_W)) u_pass_narrow (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid && (mode == BWA_PASS_NARROW)),
      .in_ready  (pn_rdy),
      .in_word   (din_m),
      .out_valid (pn_ov),
      .out_ready (out_ready),
      .out_word  (pn_d)
   );

   bwa_join #(.HALF_W(HALF_W)) u_join (
      .clk       (clk),
      .rst_n     (rst_n),
      .little    (little),
      .in_valid  (in_valid && (mode == BWA_JOIN)),
      .in_ready  (jn_rdy),
      .in_half   (din_m[HALF_W-1:0]),
      .out_valid (jn_ov),
      .out_ready (out_ready),
      .out_word  (jn_d)
   );

   bwa_split #(.HALF_W(HALF_W)) u_split (
      .clk       (clk),
      .rst_n     (rst_n),
      .little    (little),
      .in_valid  (in_valid && (mode == BWA_SPLIT)),
      .in_ready  (sp_rdy),
      .in_word   (din_m),
      .out_valid (sp_ov),
      .out_ready (out_ready),
      .out_half  (sp_d)
   );

   logic              sel_rdy, sel_ov;
   logic [FULL_W-1:0] sel_d;

   always_comb begin
      case (mode)
         BWA_PASS_WIDE:   begin sel_rdy = pw_rdy; sel_ov = pw_ov; sel_d = pw_d; end
         BWA_PASS_NARROW: begin sel_rdy = pn_rdy; sel_ov = pn_ov; sel_d = pn_d; end
         BWA_JOIN:        begin sel_rdy = jn_rdy; sel_ov = jn_ov; sel_d = jn_d; end
         default:         begin sel_rdy = sp_rdy; sel_ov = sp_ov;
                                sel_d = {{HALF_W{1'b0}}, sp_d}; end
      endcase
   end

   assign in_ready  = rst_n && sel_rdy;
   assign out_valid = sel_ov;
   assign out_data  = sel_d;

endmodule

// File: rtl/bwa_chk.sv
module bwa_chk #(
   parameter int HALF_W = 9,
   localparam int FULL_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_out_narrow,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [FULL_W-1:0] out_data
);

   logic out_narrow_q;
   always_ff @(posedge clk) begin
      if (!rst_n) out_narrow_q <= cfg_out_narrow;
   end

   // R10
   reset_clears_valid_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   // R10
   no_ready_in_reset_chk: assert property (@(posedge clk)
      !rst_n |-> !in_ready);

   // R11
   stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_narrow_q) |-> (out_data[FULL_W-1:HALF_W] == '0));

endmodule

bind bus_width_adapter bwa_chk #(.HALF_W(HALF_W)) u_bwa_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_out_narrow (cfg_out_narrow),
   .in_ready       (in_ready),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_data       (out_data)
);

// File: tb/bus_width_adapter_test.sv
module bus_width_adapter_test;

   localparam int HW = 9;
   localparam int FW = 2 * HW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cfg_in_narrow = 1'b0, cfg_out_narrow = 1'b0, cfg_little = 1'b0;
   logic          in_valid = 1'b0, out_ready = 1'b0;
   logic [FW-1:0] in_data = '0;
   logic          in_ready, out_valid;
   logic [FW-1:0] out_data;

   bus_width_adapter #(.HALF_W(HW)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_in_narrow(cfg_in_narrow), .cfg_out_narrow(cfg_out_narrow), .cfg_little(cfg_little),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   localparam logic [HW-1:0] A  = 9'h1A5, B  = 9'h0C3;
   localparam logic [HW-1:0] HA = 9'h0AB, HB = 9'h123, HC = 9'h1F0, HD = 9'h00F;
   localparam logic [HW-1:0] Z  = 9'h000;

   typedef struct packed {
      logic          in_n, out_n, lit;
      logic [FW-1:0] d0, d1, e0, e1;
   } vec_t;

   localparam vec_t TBL [8] = '{
      {1'b0, 1'b0, 1'b0, {HA, HB}, {HC, HD}, {HA, HB}, {HC, HD}},
      {1'b0, 1'b0, 1'b1, {HA, HB}, {HC, HD}, {HA, HB}, {HC, HD}},
      {1'b1, 1'b1, 1'b0, {9'h1FF, A}, {9'h155, B}, {Z, A}, {Z, B}},
      {1'b1, 1'b1, 1'b1, {9'h1FF, A}, {9'h155, B}, {Z, A}, {Z, B}},
      {1'b1, 1'b0, 1'b0, {9'h1FF, A}, {9'h155, B}, {A, B}, {Z, Z}},
      {1'b1, 1'b0, 1'b1, {9'h1FF, A}, {9'h155, B}, {B, A}, {Z, Z}},
      {1'b0, 1'b1, 1'b0, {HA, HB}, {Z, Z}, {Z, HA}, {Z, HB}},
      {1'b0, 1'b1, 1'b1, {HA, HB}, {Z, Z}, {Z, HB}, {Z, HA}}
   };

   function automatic string tag_of(input vec_t v);
      if (v.in_n == v.out_n) return v.in_n ? "R9 narrow pass" : "R8 wide pass";
      if (v.in_n)            return v.lit ? "R5 join little" : "R4 join big";
      return v.lit ? "R7 split little" : "R6 split big";
   endfunction

   // Called at a falling edge; returns at a falling edge.
   // R3: configuration pins are flipped right after reset releases.
   task automatic reset_with(input logic in_n, input logic out_n, input logic lit);
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      cfg_in_narrow = in_n; cfg_out_narrow = out_n; cfg_little = lit;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cfg_in_narrow = ~in_n; cfg_out_narrow = ~out_n; cfg_little = ~lit;
   endtask

   task automatic drive_collect(input vec_t v, input bit stall, input string tag);
      int nin, nout, ic, oc;
      logic [FW-1:0] got [2];
      nin  = (!v.in_n && v.out_n) ? 1 : 2;
      nout = (v.in_n && !v.out_n) ? 1 : 2;
      ic = 0; oc = 0;
      got[0] = '0; got[1] = '0;
      for (int cyc = 0; cyc < 40 && oc < nout; cyc++) begin
         in_valid  = (ic < nin);
         in_data   = (ic == 0) ? v.d0 : v.d1;
         out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
         #1;
         if (in_valid && in_ready) ic++;
         if (out_valid && out_ready) begin
            if (oc < 2) got[oc] = out_data;
            oc++;
         end
         @(negedge clk);
      end
      in_valid = 1'b0; out_ready = 1'b1;
      for (int k = 0; k < 4; k++) begin
         #1;
         if (out_valid) oc++;
         @(negedge clk);
      end
      chk(oc == nout, {tag, " R1 R3 transfer count"}, FW'(oc), FW'(nout));
      chk(got[0] == v.e0, {tag, " R2 first word"}, got[0], v.e0);
      if (nout == 2) chk(got[1] == v.e1, {tag, " R2 second word"}, got[1], v.e1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      vec_t dv;
      @(negedge clk);

      // R10: reset state with input offered
      rst_n = 1'b0; in_valid = 1'b1; in_data = {HA, HB};
      @(negedge clk); #1;
      chk(in_ready == 1'b0, "R10 in_ready low in reset", FW'(in_ready), FW'(0));
      chk(out_valid == 1'b0, "R10 out_valid low in reset", FW'(out_valid), FW'(0));
      @(negedge clk);

      // Table walk: every width/order combination, odd entries with stalls
      for (int i = 0; i < 8; i++) begin
         reset_with(TBL[i].in_n, TBL[i].out_n, TBL[i].lit);
         drive_collect(TBL[i], (i % 2) == 1, tag_of(TBL[i]));
      end

      // R8 latency and R11 stall in wide pass mode
      reset_with(1'b0, 1'b0, 1'b0);
      in_valid = 1'b1; in_data = {HA, HB}; out_ready = 1'b0; #1;
      chk(out_valid == 1'b0, "R8 not valid before accepting edge", FW'(out_valid), FW'(0));
      @(negedge clk); in_valid = 1'b0; #1;
      chk(out_valid == 1'b1, "R8 valid after accepting edge", FW'(out_valid), FW'(1));
      chk(out_data == {HA, HB}, "R8 pass data", out_data, {HA, HB});
      in_valid = 1'b1; in_data = {HC, HD};
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b1 && out_data == {HA, HB}, "R11 held under stall", out_data, {HA, HB});
      chk(in_ready == 1'b0, "R11 in_ready low when full", FW'(in_ready), FW'(0));
      in_valid = 1'b0;
      out_ready = 1'b1;
      @(negedge clk); #1;
      chk(out_valid == 1'b0, "R11 drained after pop", FW'(out_valid), FW'(0));

      // R10: half-built word dropped by reset
      @(negedge clk);
      reset_with(1'b1, 1'b0, 1'b0);
      in_valid = 1'b1; in_data = {Z, A}; out_ready = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R10 no partial word shown", FW'(out_valid), FW'(0));
      @(negedge clk);
      reset_with(1'b1, 1'b0, 1'b0);
      dv = '{in_n: 1'b1, out_n: 1'b0, lit: 1'b0,
             d0: {Z, 9'h07E}, d1: {Z, 9'h181}, e0: {9'h07E, 9'h181}, e1: '0};
      drive_collect(dv, 1'b0, "R10 after discard");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule